// File: doc/BRIEF.md
# Receive Loss-of-Signal Detector

This block decides whether a receive line has lost its signal. An analog front end supplies two level flags once per unit interval (UI). One flag says the received peak is under the declare threshold. The other says the peak is over the clear threshold, which sits slightly higher. The block qualifies each flag with a persistence count measured in UIs. It declares loss of signal after an unbroken run of "under" intervals, and it removes the declaration after an unbroken run of "over" intervals.

While loss of signal is declared, the recovered NRZ bit stream passing through the block is squelched to zero. Each declaration also sets a sticky event bit, which a status-read pulse clears.

Detection is switched off, and the persistence count is reset, by any of three controls:
- a software override;
- receive monitor mode;
- local loopback.

The recovered data is a stream with a valid strobe only (`ui_valid`, one pulse per UI). The line clock cannot be stalled, so there is no ready signal and no back-pressure. Each input bit is presented exactly once, and one output beat with the same valid timing appears one cycle later.

Top module: `rx_los_detector`

## Requirements
- R1: In the no-loss state, `los` rises after `PERSIST_UI` consecutive valid UIs with `below_declare`=1. It is visible from the clock edge that samples the last of those UIs.
- R2: In the loss state, `los` falls after `PERSIST_UI` consecutive valid UIs with `above_clear`=1. It is visible from the clock edge that samples the last of those UIs.
- R3: Any valid UI that lacks the flag required in the current state restarts the run count from zero. Cycles with `ui_valid`=0 neither advance nor break a run.
- R4: One cycle after each input cycle, `nrz_valid` equals that cycle's `ui_valid`. `nrz_data` equals `ui_valid & rx_nrz & ~los`, where `los` is the value held before that edge.
- R5: While `los_override`=1, `los` is 0 and the run count is held at zero. After release, a full new run is needed to declare.
- R6: While `monitor_mode`=1, `los` is 0 and the run count is held at zero.
- R7: While `local_loopback`=1, `los` is 0 and the run count is held at zero.
- R8: `los_event` is set by each declaration and cleared by a `status_clr` pulse. A declaration in the same cycle as `status_clr` leaves the bit set.
- R9: After reset, `los`, `los_event`, `nrz_valid` and `nrz_data` are 0 and the run count is zero.
- R10: `PERSIST_UI` must lie between 10 and 255. The default is 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ui_valid | input | 1 | One pulse per unit interval; qualifies flags and data |
| below_declare | input | 1 | Peak under declare threshold in this UI |
| above_clear | input | 1 | Peak over clear threshold in this UI |
| rx_nrz | input | 1 | Recovered NRZ data bit for this UI |
| los_override | input | 1 | Forces detection off |
| monitor_mode | input | 1 | Receive monitor mode active; detection off |
| local_loopback | input | 1 | Local loopback active; detection off |
| status_clr | input | 1 | Status read pulse; clears the sticky event |
| nrz_valid | output | 1 | Output data beat valid |
| nrz_data | output | 1 | Squelched NRZ data |
| los | output | 1 | Loss-of-signal condition |
| los_event | output | 1 | Sticky declaration event |

## Verification
Every result is due on the first clock edge after the input cycle that causes it:
- `los` changes on the edge that samples the final UI of a qualifying run.
- A disable control clears `los` on the edge that samples it.
- The sticky event sets together with `los`.
- Each data beat comes out one edge after it is taken in.

The bench drives inputs and compares all outputs at the falling edge. It updates a behavioural model once per driven cycle, so the model holds the value each output must show after the next rising edge. Runs of length one short of the threshold, broken runs, idle gaps inside runs, and disables asserted mid-run are checked against that one-edge timing.

// File: rtl/rx_los_pkg.sv
package rx_los_pkg;
  typedef enum logic {
    LINK_PRESENT = 1'b0,
    LINK_LOST    = 1'b1
  } link_state_e;

  localparam int unsigned PERSIST_MIN = 10;
  localparam int unsigned PERSIST_MAX = 255;
endpackage

// File: rtl/rx_los_persist.sv
module rx_los_persist
  import rx_los_pkg::*;
#(
  parameter int unsigned PERSIST_UI = 110
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ui_valid,
  input  logic below_declare,
  input  logic above_clear,
  input  logic detect_off,
  output logic los,
  output logic declare_pulse
);
  localparam int unsigned CNT_W = $clog2(PERSIST_UI);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(PERSIST_UI - 1);

  link_state_e      state_q;
  logic [CNT_W-1:0] run_q;
  logic             want;
  logic             run_done;

  // the flag that extends the run depends on the current state
  assign want     = (state_q == LINK_PRESENT) ? below_declare : above_clear;
  assign run_done = (run_q == RUN_LAST);

  assign declare_pulse = !detect_off && ui_valid && want && run_done
                         && (state_q == LINK_PRESENT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LINK_PRESENT;
      run_q   <= '0;
    end else if (detect_off) begin
      state_q <= LINK_PRESENT;
      run_q   <= '0;
    end else if (ui_valid) begin
      if (!want) begin
        run_q <= '0;
      end else if (run_done) begin
        run_q   <= '0;
        state_q <= (state_q == LINK_PRESENT) ? LINK_LOST : LINK_PRESENT;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign los = (state_q == LINK_LOST);

  p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_LAST);
  p_declare_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(ui_valid && below_declare && !detect_off));
  p_clear_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> ($past(detect_off) || $past(ui_valid && above_clear)));
  p_off_forces_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    detect_off |=> (!los && run_q == '0));
  p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ui_valid && !detect_off) |=> ($stable(los) && $stable(run_q)));
endmodule

// File: rtl/rx_los_squelch.sv
module rx_los_squelch (
  input  logic clk,
  input  logic rst_n,
  input  logic ui_valid,
  input  logic rx_nrz,
  input  logic los,
  output logic nrz_valid,
  output logic nrz_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrz_valid <= 1'b0;
      nrz_data  <= 1'b0;
    end else begin
      nrz_valid <= ui_valid;
      nrz_data  <= ui_valid && rx_nrz && !los;
    end
  end

  p_squelch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ui_valid && los) |=> !nrz_data);
  p_beat_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ui_valid |=> nrz_valid);
endmodule

// File: rtl/rx_los_status.sv
module rx_los_status (
  input  logic clk,
  input  logic rst_n,
  input  logic declare_pulse,
  input  logic status_clr,
  output logic los_event
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) los_event <= 1'b0;
    else        los_event <= declare_pulse || (los_event && !status_clr);
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    declare_pulse |=> los_event);
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !declare_pulse) |=> !los_event);
endmodule

// File: rtl/rx_los_detector.sv
module rx_los_detector
  import rx_los_pkg::*;
#(
  parameter int unsigned PERSIST_UI = 110
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ui_valid,
  input  logic below_declare,
  input  logic above_clear,
  input  logic rx_nrz,
  input  logic los_override,
  input  logic monitor_mode,
  input  logic local_loopback,
  input  logic status_clr,
  output logic nrz_valid,
  output logic nrz_data,
  output logic los,
  output logic los_event
);
  logic detect_off;
  logic declare_pulse;

  // R5, R6, R7: any of the three controls stops detection
  assign detect_off = los_override || monitor_mode || local_loopback;

  initial begin
    p_persist_range_r10: assert (PERSIST_UI >= PERSIST_MIN && PERSIST_UI <= PERSIST_MAX);
  end

  rx_los_persist #(.PERSIST_UI(PERSIST_UI)) u_persist (
    .clk           (clk),
    .rst_n         (rst_n),
    .ui_valid      (ui_valid),
    .below_declare (below_declare),
    .above_clear   (above_clear),
    .detect_off    (detect_off),
    .los           (los),
    .declare_pulse (declare_pulse)
  );

  rx_los_squelch u_squelch (
    .clk       (clk),
    .rst_n     (rst_n),
    .ui_valid  (ui_valid),
    .rx_nrz    (rx_nrz),
    .los       (los),
    .nrz_valid (nrz_valid),
    .nrz_data  (nrz_data)
  );

  rx_los_status u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .declare_pulse (declare_pulse),
    .status_clr    (status_clr),
    .los_event     (los_event)
  );

  p_event_with_los_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> los_event);
  p_monitor_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    monitor_mode |=> !los);
  p_loopback_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    local_loopback |=> !los);
endmodule

// File: tb/rx_los_detector_tb.sv
module rx_los_detector_tb;
  localparam int N = 110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ui_valid = 0, below_declare = 0, above_clear = 0, rx_nrz = 0;
  logic los_override = 0, monitor_mode = 0, local_loopback = 0, status_clr = 0;
  logic nrz_valid, nrz_data, los, los_event;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R9";

  // behavioural reference state (value after the next rising edge)
  int m_run = 0;
  bit m_los = 0, m_evt = 0, m_dv = 0, m_dout = 0;

  always #5 clk = ~clk;

  rx_los_detector #(.PERSIST_UI(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .ui_valid(ui_valid), .below_declare(below_declare),
    .above_clear(above_clear), .rx_nrz(rx_nrz), .los_override(los_override),
    .monitor_mode(monitor_mode), .local_loopback(local_loopback),
    .status_clr(status_clr), .nrz_valid(nrz_valid), .nrz_data(nrz_data),
    .los(los), .los_event(los_event)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  task automatic model_step();
    bit off, want, decl;
    decl = 0;
    off = los_override || monitor_mode || local_loopback;
    m_dv = ui_valid;
    m_dout = ui_valid && rx_nrz && !m_los;
    if (!rst_n) begin
      m_run = 0; m_los = 0; m_evt = 0; m_dv = 0; m_dout = 0;
    end else begin
      if (off) begin
        m_run = 0; m_los = 0;
      end else if (ui_valid) begin
        want = m_los ? above_clear : below_declare;
        if (!want) m_run = 0;
        else begin
          m_run++;
          if (m_run == N) begin
            m_run = 0;
            if (!m_los) decl = 1;
            m_los = !m_los;
          end
        end
      end
      m_evt = decl || (m_evt && !status_clr);
    end
  endtask

  // set inputs, advance the model, then compare after the edge at the falling edge
  task automatic step(input bit v, input bit b, input bit a, input bit d, input bit clr);
    ui_valid = v; below_declare = b; above_clear = a; rx_nrz = d; status_clr = clr;
    model_step();
    @(negedge clk);
    cycles++;
    check(cur_req, "los", los, m_los);
    check("R8", "los_event", los_event, m_evt);
    check("R4", "nrz_valid", nrz_valid, m_dv);
    check("R4", "nrz_data", nrz_data, m_dout);
  endtask

  task automatic below_run(input int n);
    for (int i = 0; i < n; i++) begin
      step(1, 1, 0, $urandom_range(0, 1), 0);
      if (i % 7 == 3) step(0, 0, 0, 1, 0); // idle gap inside a run (R3)
    end
  endtask

  task automatic above_run(input int n);
    for (int i = 0; i < n; i++) begin
      step(1, 0, 1, $urandom_range(0, 1), 0);
      if (i % 5 == 2) step(0, 1, 0, 1, 0);
    end
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R9";
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0);

    cur_req = "R3";  // one short, break, one short again
    below_run(N - 1);
    step(1, 0, 0, 1, 0);
    below_run(N - 1);
    cur_req = "R1";
    step(1, 1, 0, 1, 0);            // completes run: declare
    cur_req = "R8";
    step(0, 0, 0, 0, 1);            // read clears event
    cur_req = "R4";
    for (int i = 0; i < 20; i++) step(1, $urandom_range(0, 1), 0, 1, 0);

    cur_req = "R2";
    above_run(50);
    step(1, 0, 0, 1, 0);            // break clear run
    above_run(N - 1);
    step(1, 0, 1, 1, 0);            // clear
    cur_req = "R4";
    for (int i = 0; i < 20; i++) step(1, 0, 0, $urandom_range(0, 1), 0);

    cur_req = "R8";                 // declare with simultaneous read
    below_run(N - 1);
    step(1, 1, 0, 1, 1);
    step(0, 0, 0, 0, 0);

    cur_req = "R5";
    los_override = 1; step(1, 1, 0, 1, 0);
    los_override = 0;
    below_run(60);
    los_override = 1; step(1, 1, 0, 1, 0);
    los_override = 0;
    below_run(N - 1);
    step(1, 1, 0, 1, 0);            // full fresh run declares
    step(0, 0, 0, 0, 1);

    cur_req = "R6";
    monitor_mode = 1;
    below_run(N + 20);
    monitor_mode = 0;
    step(0, 0, 0, 0, 0);

    cur_req = "R7";
    below_run(N);                   // declare again
    local_loopback = 1;
    below_run(N + 20);
    local_loopback = 0;
    step(0, 0, 0, 0, 0);
    below_run(N - 1);               // count restarted: still present

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule